// File: doc/BRIEF.md
# Age-Counter Way Replacement Unit

This block decides which way of a 4-way set-associative cache gets evicted when a lookup misses. For every set it holds one valid bit and one 2-bit age counter per way. A cache controller reports each hit and each fill through a touch strobe that carries the set index and way number. When it needs room, it raises a pick request for a set, and one cycle later it receives the chosen way.

Touching a valid way makes it the youngest. Every valid way in the same set that was younger than the touched way ages by one. The counters stop at 3. Because of this, a full set always holds the four ages 0, 1, 2 and 3, and the way at 3 is the one used least recently. Empty ways are always filled before anything is evicted. A mode input replaces the age-based choice with the low bits of a free-running LFSR, so the two policies can be compared on the same traffic. Tag storage, data storage and the refill path sit outside this block.

Top module: `way_age_repl`

## Requirements
- R1: Reset clears every age counter to 0 and every valid bit, and holds `victim_valid` low.
- R2: `victim_valid` is high in exactly the cycle after a cycle with `pick_req` high, and `victim_way` carries the choice for the set that was presented with that request.
- R3: If the requested set has an invalid way, the victim is the lowest-numbered invalid way. This holds in both modes.
- R4: A fill (`touch_en` and `touch_fill` high) marks the way valid and sets its counter to 0. Every other valid way whose counter is below the filled way's previous age goes up by one, and an invalid filled way counts as older than any age.
- R5: A hit (`touch_en` high, `touch_fill` low) to a valid way sets its counter to 0 and adds one to the counters that were below its previous age. Counters above that age keep their value.
- R6: With `rand_mode` low and the set full, the victim is the way with the highest counter. That counter is 3 in every reachable state. Ties go to the lower way number.
- R7: A hit to a way that is not valid changes neither the counters nor the valid bits.
- R8: When a pick and a touch reach the same set in one cycle, the victim is computed from the state before the touch.
- R9: A touch changes only the state of the set it names.
- R10: With `rand_mode` high and the set full, the victim is the low two bits of an 8-bit Galois LFSR (taps 0xB8, seed 1 at reset, one step per clock), so every way is reachable whatever the ages are.
- R11: In a full set, exactly one way has a counter equal to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | SET_W (4) | Set addressed by the touch and the pick in this cycle |
| touch_en | input | 1 | A hit or a fill to `touch_way` happens this cycle |
| touch_fill | input | 1 | The touch is a fill (1) or a hit (0) |
| touch_way | input | 2 | Way number of the touch |
| pick_req | input | 1 | Request a victim for `set_idx` |
| rand_mode | input | 1 | 0 selects age-based choice, 1 selects LFSR choice for full sets |
| victim_way | output | 2 | Chosen way, registered |
| victim_valid | output | 1 | `victim_way` answers the request of the previous cycle |

## Verification
Victim selection and the counter update can both act on the same set in one clock cycle. A pick request can arrive together with the hit or fill that follows a miss. The bench provokes this with a single vector that hits the current oldest way of a full set and asks for a victim in the same cycle. It expects the pre-update oldest way to come back. The very next pick on that set must then return the way the update aged to 3. This shows that the selection read the old state and that the write still landed.

// File: rtl/repl_pkg.sv
`timescale 1ns/1ps
package repl_pkg;
  localparam int WAYS    = 4;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int AGE_W   = $clog2(WAYS);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  typedef logic [WAY_W-1:0]            way_t;
  typedef logic [AGE_W-1:0]            age_t;
  typedef age_t [WAYS-1:0]             age_vec_t;
  typedef logic [WAYS-1:0]             valid_vec_t;

  // New ages after a touch of way w. An invalid touched way ranks above
  // every age, so all valid, unsaturated ways get older on a fill into it.
  function automatic age_vec_t age_after_touch(age_vec_t a, valid_vec_t v, way_t w);
    age_vec_t        r;
    logic [AGE_W:0]  ref_age;
    ref_age = v[w] ? {1'b0, a[w]} : {1'b1, {AGE_W{1'b0}}};
    r = a;
    for (int i = 0; i < WAYS; i++) begin
      if (way_t'(i) == w)
        r[i] = '0;
      else if (v[i] && ({1'b0, a[i]} < ref_age) && (a[i] != AGE_MAX))
        r[i] = a[i] + 1'b1;
    end
    return r;
  endfunction

  // Highest counter wins; strict compare keeps the lowest index on ties.
  function automatic way_t oldest_way(age_vec_t a);
    way_t best;
    age_t top;
    best = '0;
    top  = a[0];
    for (int i = 1; i < WAYS; i++) begin
      if (a[i] > top) begin
        top  = a[i];
        best = way_t'(i);
      end
    end
    return best;
  endfunction

  // Lowest-numbered invalid way (meaningful only if one exists).
  function automatic way_t first_invalid(valid_vec_t v);
    way_t f;
    f = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!v[i]) f = way_t'(i);
    end
    return f;
  endfunction
endpackage

// File: rtl/repl_lfsr.sv
`timescale 1ns/1ps
module repl_lfsr
  import repl_pkg::*;
#(
  parameter int               LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic clk,
  input  logic rst_n,
  output way_t rnd_way
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= LFSR_W'(1);
    else if (state_q[0])
      state_q <= (state_q >> 1) ^ LFSR_TAPS;
    else
      state_q <= state_q >> 1;
  end

  assign rnd_way = state_q[WAY_W-1:0];

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/repl_age_bank.sv
`timescale 1ns/1ps
module repl_age_bank
  import repl_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             touch_en,
  input  logic             touch_fill,
  input  way_t             touch_way,
  output age_vec_t         rd_ages,
  output valid_vec_t       rd_valid
);
  age_vec_t   ages_q  [NUM_SETS];
  valid_vec_t valid_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic sel_this;
    logic upd_this;
    logic [WAYS-1:0] at_max;

    assign sel_this = touch_en && (set_idx == SET_W'(s));
    // R7: a hit on an invalid way is dropped
    assign upd_this = sel_this && (touch_fill || valid_q[s][touch_way]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ages_q[s]  <= '0;
        valid_q[s] <= '0;
      end else if (upd_this) begin
        ages_q[s] <= age_after_touch(ages_q[s], valid_q[s], touch_way);
        if (touch_fill) valid_q[s][touch_way] <= 1'b1;
      end
    end

    always_comb begin
      for (int i = 0; i < WAYS; i++) at_max[i] = (ages_q[s][i] == AGE_MAX);
    end

    // R11
    one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&valid_q[s]) |-> ($countones(at_max) == 1));
  end

  assign rd_ages  = ages_q[set_idx];
  assign rd_valid = valid_q[set_idx];

  // Named events for the checks below
  logic             eff_touch_q;
  logic             last_fill_q;
  logic [SET_W-1:0] last_set_q;
  way_t             last_way_q;
  logic             eff_touch;

  assign eff_touch = touch_en && (touch_fill || rd_valid[touch_way]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_touch_q <= 1'b0;
      last_fill_q <= 1'b0;
      last_set_q  <= '0;
      last_way_q  <= '0;
    end else begin
      eff_touch_q <= eff_touch;
      last_fill_q <= touch_en && touch_fill;
      last_set_q  <= set_idx;
      last_way_q  <= touch_way;
    end
  end

  // R5
  touched_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_touch_q |-> (ages_q[last_set_q][last_way_q] == '0));

  // R4
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fill_q |-> valid_q[last_set_q][last_way_q]);
endmodule

// File: rtl/repl_victim_sel.sv
`timescale 1ns/1ps
module repl_victim_sel
  import repl_pkg::*;
(
  input  age_vec_t   ages,
  input  valid_vec_t valid,
  input  logic       rand_mode,
  input  way_t       rnd_way,
  output way_t       sel_way,
  output logic       sel_from_invalid
);
  assign sel_from_invalid = !(&valid);

  always_comb begin
    if (sel_from_invalid)
      sel_way = first_invalid(valid);
    else if (rand_mode)
      sel_way = rnd_way;
    else
      sel_way = oldest_way(ages);
  end
endmodule

// File: rtl/way_age_repl.sv
`timescale 1ns/1ps
module way_age_repl
  import repl_pkg::*;
#(
  parameter int               NUM_SETS  = 16,
  parameter int               LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  localparam int              SET_W     = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             touch_en,
  input  logic             touch_fill,
  input  logic [1:0]       touch_way,
  input  logic             pick_req,
  input  logic             rand_mode,
  output logic [1:0]       victim_way,
  output logic             victim_valid
);
  age_vec_t   cur_ages;
  valid_vec_t cur_valid;
  way_t       rnd_way;
  way_t       sel_way;
  logic       sel_from_invalid;

  repl_age_bank #(.NUM_SETS(NUM_SETS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (set_idx),
    .touch_en   (touch_en),
    .touch_fill (touch_fill),
    .touch_way  (touch_way),
    .rd_ages    (cur_ages),
    .rd_valid   (cur_valid)
  );

  repl_lfsr #(.LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rnd_way (rnd_way)
  );

  repl_victim_sel u_sel (
    .ages             (cur_ages),
    .valid            (cur_valid),
    .rand_mode        (rand_mode),
    .rnd_way          (rnd_way),
    .sel_way          (sel_way),
    .sel_from_invalid (sel_from_invalid)
  );

  // R8: choice sampled from pre-touch state at the same edge as the update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_way   <= '0;
      victim_valid <= 1'b0;
    end else begin
      victim_valid <= pick_req;
      if (pick_req) victim_way <= sel_way;
    end
  end

  // R2
  valid_follows_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_req |=> victim_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_req |=> !victim_valid);
  // R3
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_req && sel_from_invalid) |-> !cur_valid[sel_way]);
  // R6
  oldest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_req && !rand_mode && (&cur_valid)) |-> (cur_ages[sel_way] == AGE_MAX));
endmodule

// File: tb/sim_way_age_repl.sv
`timescale 1ns/1ps
module sim_way_age_repl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] set_idx = '0;
  logic       touch_en = 1'b0;
  logic       touch_fill = 1'b0;
  logic [1:0] touch_way = '0;
  logic       pick_req = 1'b0;
  logic       rand_mode = 1'b0;
  logic [1:0] victim_way;
  logic       victim_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  way_age_repl u0 (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .touch_en(touch_en),
    .touch_fill(touch_fill), .touch_way(touch_way), .pick_req(pick_req),
    .rand_mode(rand_mode), .victim_way(victim_way), .victim_valid(victim_valid)
  );

  // {touch, fill, way[1:0], pick, set[3:0], expected victim[1:0]}
  localparam int NV = 20;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0,1'b0,2'd0,1'b1,4'd2,2'd0},  //  0 empty set -> way 0        R3
    {1'b1,1'b1,2'd0,1'b0,4'd2,2'd0},  //  1 fill w0
    {1'b0,1'b0,2'd0,1'b1,4'd2,2'd1},  //  2 lowest invalid is 1       R3
    {1'b1,1'b1,2'd1,1'b0,4'd2,2'd0},  //  3 fill w1
    {1'b1,1'b1,2'd2,1'b0,4'd2,2'd0},  //  4 fill w2
    {1'b1,1'b1,2'd3,1'b0,4'd2,2'd0},  //  5 fill w3 -> ages 3,2,1,0
    {1'b0,1'b0,2'd0,1'b1,4'd2,2'd0},  //  6 oldest w0                R4
    {1'b1,1'b0,2'd2,1'b0,4'd2,2'd0},  //  7 hit w2 -> 3,2,0,1
    {1'b0,1'b0,2'd0,1'b1,4'd2,2'd0},  //  8                           R5
    {1'b1,1'b0,2'd0,1'b0,4'd2,2'd0},  //  9 hit w0 -> 0,3,1,2
    {1'b0,1'b0,2'd0,1'b1,4'd2,2'd1},  // 10                           R5
    {1'b1,1'b0,2'd1,1'b0,4'd2,2'd0},  // 11 hit w1 -> 1,0,2,3
    {1'b0,1'b0,2'd0,1'b1,4'd2,2'd3},  // 12                           R6
    {1'b1,1'b0,2'd3,1'b0,4'd2,2'd0},  // 13 hit w3 -> 2,1,3,0
    {1'b1,1'b0,2'd2,1'b1,4'd2,2'd2},  // 14 pick+hit w2 same cycle   R8
    {1'b0,1'b0,2'd0,1'b1,4'd2,2'd0},  // 15 now 3,2,0,1              R5
    {1'b1,1'b1,2'd0,1'b0,4'd5,2'd0},  // 16 fill set 5 w0
    {1'b0,1'b0,2'd0,1'b1,4'd2,2'd0},  // 17 set 2 untouched          R9
    {1'b1,1'b0,2'd1,1'b0,4'd5,2'd0},  // 18 hit invalid w1 of set 5
    {1'b0,1'b0,2'd0,1'b1,4'd5,2'd1}   // 19 w1 still invalid         R7
  };

  function automatic string row_tag(int i);
    case (i)
      0, 2:           return "R3";
      6:              return "R4";
      8, 10, 15:      return "R5";
      12:             return "R6";
      14:             return "R8";
      17:             return "R9";
      19:             return "R7";
      default:        return "R2";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit t, bit f, logic [1:0] w, bit p, logic [3:0] s);
    touch_en = t; touch_fill = f; touch_way = w; pick_req = p; set_idx = s;
    @(posedge clk);
    @(negedge clk);
    touch_en = 1'b0; touch_fill = 1'b0; pick_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    int seen [4];
    int not_oldest;
    repeat (3) @(negedge clk);
    // R1: output idle in and right after reset
    chk(victim_valid == 1'b0, "R1", victim_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(victim_valid == 1'b0, "R1", victim_valid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      drive(v[10], v[9], v[8:7], v[6], v[5:2]);
      if (v[6]) begin
        chk(victim_valid == 1'b1, "R2", victim_valid, 1);
        chk(victim_way == v[1:0], row_tag(i), victim_way, v[1:0]);
      end else begin
        chk(victim_valid == 1'b0, "R2", victim_valid, 0);
      end
    end

    // R10: full set 7 (ages 3,2,1,0), random picks reach all ways
    for (int w = 0; w < 4; w++) drive(1'b1, 1'b1, 2'(w), 1'b0, 4'd7);
    rand_mode = 1'b1;
    for (int k = 0; k < 4; k++) seen[k] = 0;
    not_oldest = 0;
    set_idx = 4'd7;
    pick_req = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      seen[victim_way]++;
      if (victim_way != 2'd0) not_oldest++;
    end
    pick_req = 1'b0;
    for (int k = 0; k < 4; k++) chk(seen[k] > 0, "R10", seen[k], 1);
    chk(not_oldest > 0, "R10", not_oldest, 1);

    // R3 still holds in random mode
    drive(1'b0, 1'b0, 2'd0, 1'b1, 4'd9);
    chk(victim_way == 2'd0, "R3", victim_way, 0);
    rand_mode = 1'b0;
    drive(1'b0, 1'b0, 2'd0, 1'b1, 4'd7);
    chk(victim_way == 2'd0, "R6", victim_way, 0);

    // R1: reset mid-run empties set 2
    rst_n = 1'b0;
    @(negedge clk);
    chk(victim_valid == 1'b0, "R1", victim_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd0, 1'b1, 4'd2);
    chk(victim_way == 2'd0 && victim_valid, "R1", victim_way, 0);
    drive(1'b1, 1'b1, 2'd0, 1'b0, 4'd2);
    drive(1'b0, 1'b0, 2'd0, 1'b1, 4'd2);
    chk(victim_way == 2'd1, "R1", victim_way, 1);

    done = 1'b1;
    finish_run();
  end
endmodule